// File: doc/BRIEF.md
# Tiled Edge-Function Triangle Coverage Unit

This unit decides which screen samples a single triangle covers. It accepts three projected vertices in unsigned fixed-point screen coordinates with four fractional bits. From them it forms three linear edge functions, one per side. It then visits the triangle's bounding box, clamped to the screen, in square tiles of 4x4 pixels, and tests all sixteen pixel-center samples of a tile at the same time. For each tile that holds at least one covered sample, it hands out a 16-bit coverage mask over a valid/ready output.

Each tile is classified before its samples are used. If any one edge has the whole tile on its outer side, the tile is rejected. If the tile is inside all three edges, it is accepted whole and the per-sample results are not consulted. Only the tiles in between take their mask from the sixteen individual tests. Edge values move from tile to tile by addition alone, using per-edge step constants that are fixed when the triangle is set up. Triangles of either winding are brought to one orientation, so one inside test serves both.

A triangle is accepted only while the unit is idle. The upstream stage waits for `in_ready` to return before it presents the next triangle.

Top module: `tri_coverage_raster`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Each pixel (px,py) has one sample at (px+0.5, py+0.5). For edge i, with j = i+1 wrapping from 2 to 0, the edge function is (x−Xi)(Yj−Yi) − (y−Yi)(Xj−Xi). A sample is covered only when the three oriented edge values are all strictly below zero. A sample lying exactly on an edge is not covered.
- R3: Coverage does not depend on winding. If E0 evaluated at vertex 2 is positive, all three edge functions are negated. Listing the same vertices in the opposite order gives the same tiles and masks.
- R4: A triangle of zero area emits no tiles, and `in_ready` returns to 1 afterwards.
- R5: A tile numbered (tx,ty) covers pixels 4·tx..4·tx+3 by 4·ty..4·ty+3. Bit j·4+i of `out_mask` is the sample of pixel (4·tx+i, 4·ty+j).
- R6: Tiles leave in row-major order, with y outer and x inner, within the bounding box. A tile with no covered sample is never emitted.
- R7: `out_full` is 1 exactly when all sixteen samples of the emitted tile are covered. In that case `out_mask` is all ones.
- R8: The bounding box is clamped to a screen of SCR_W x SCR_H pixels. Vertices beyond the screen yield only on-screen tiles. A triangle lying entirely off screen yields none.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and the tile coordinates, mask and full flag hold their values.
- R10: `in_ready` falls in the cycle after a triangle is accepted and stays 0 until the last tile has been consumed or skipped. It is never 1 while `out_valid` is 1.
- R11: Edge accumulators are wide enough that no setup product and no step sum overflows, for any vertex positions the input width can express.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A triangle is presented |
| in_ready | output | 1 | Unit is idle and takes a triangle |
| v0_x | input | 12 | Vertex 0 x, 8.4 fixed point |
| v0_y | input | 12 | Vertex 0 y, 8.4 fixed point |
| v1_x | input | 12 | Vertex 1 x, 8.4 fixed point |
| v1_y | input | 12 | Vertex 1 y, 8.4 fixed point |
| v2_x | input | 12 | Vertex 2 x, 8.4 fixed point |
| v2_y | input | 12 | Vertex 2 y, 8.4 fixed point |
| out_valid | output | 1 | A covered tile is presented |
| out_ready | input | 1 | Downstream takes the tile |
| out_tile_x | output | TX_W (4) | Tile column |
| out_tile_y | output | TY_W (4) | Tile row |
| out_mask | output | 16 | Per-sample coverage, bit j·4+i |
| out_full | output | 1 | Tile accepted whole |

## Verification
The triangle is captured at the accepting edge. The next cycle is spent on setup, so the bench checks that `in_ready` is already 0 at the first falling edge after acceptance. The first candidate tile can appear one cycle after setup, and a new candidate is evaluated in every cycle in which the current one is either taken or skipped. Because of this, the tile results do not arrive at a fixed cycle. The bench records each tile at the falling edge before the rising edge that transfers it, and compares the recorded sequence with a per-sample model once `in_ready` has returned. Stall stability is checked by comparing the outputs across each falling edge on which `out_ready` had been held low.

// File: rtl/tri_raster_pkg.sv
package tri_raster_pkg;

    localparam int FRAC_BITS    = 4;
    localparam int PIX_BITS     = 8;
    localparam int CRD_W        = PIX_BITS + FRAC_BITS;
    localparam int TILE_LOG2    = 2;
    localparam int TILE_DIM     = 1 << TILE_LOG2;
    localparam int TILE_SAMPLES = TILE_DIM * TILE_DIM;
    // Product of two (CRD_W+2)-bit differences plus a sum and tile steps.
    localparam int EDGE_W       = 2 * CRD_W + 8;

    typedef logic signed [EDGE_W-1:0] edge_val_t;
    typedef logic [CRD_W-1:0]         crd_t;
    typedef logic [PIX_BITS-1:0]      pix_t;

    typedef struct packed {
        edge_val_t step_x;   // change per sample in x
        edge_val_t step_y;   // change per sample in y
        edge_val_t base;     // value at the tile's first sample
    } edge_coef_t;

    typedef enum logic [1:0] {
        TK_REJECT  = 2'd0,
        TK_PARTIAL = 2'd1,
        TK_FULL    = 2'd2
    } tile_kind_e;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_LOAD = 2'd1,
        WS_WALK = 2'd2
    } walk_state_e;

    function automatic edge_val_t widen(input crd_t v);
        return edge_val_t'({{(EDGE_W-CRD_W){1'b0}}, v});
    endfunction

    function automatic crd_t min3(input crd_t a, input crd_t b, input crd_t c);
        crd_t m;
        m = (a < b) ? a : b;
        return (c < m) ? c : m;
    endfunction

    function automatic crd_t max3(input crd_t a, input crd_t b, input crd_t c);
        crd_t m;
        m = (a > b) ? a : b;
        return (c > m) ? c : m;
    endfunction

    function automatic pix_t clamp_pix(input pix_t p, input pix_t lim);
        return (p > lim) ? lim : p;
    endfunction

endpackage

// File: rtl/tri_edge_setup.sv
module tri_edge_setup
    import tri_raster_pkg::*;
#(
    parameter int SCR_W = 64,
    parameter int SCR_H = 64,
    parameter int TX_W  = 4,
    parameter int TY_W  = 4
) (
    input  crd_t [2:0]           vx,
    input  crd_t [2:0]           vy,
    output edge_coef_t [2:0]     coef,
    output logic                 degenerate,
    output logic [TX_W-1:0]      tx_lo,
    output logic [TX_W-1:0]      tx_hi,
    output logic [TY_W-1:0]      ty_lo,
    output logic [TY_W-1:0]      ty_hi
);

    localparam pix_t X_LIM = pix_t'(SCR_W - 1);
    localparam pix_t Y_LIM = pix_t'(SCR_H - 1);
    localparam crd_t HALF  = crd_t'(1 << (FRAC_BITS - 1));

    crd_t x_min, x_max, y_min, y_max;
    pix_t px_lo, px_hi, py_lo, py_hi;
    crd_t org_x, org_y;
    edge_val_t area;
    logic flip;

    assign x_min = min3(vx[0], vx[1], vx[2]);
    assign x_max = max3(vx[0], vx[1], vx[2]);
    assign y_min = min3(vy[0], vy[1], vy[2]);
    assign y_max = max3(vy[0], vy[1], vy[2]);

    assign px_lo = clamp_pix(x_min[CRD_W-1:FRAC_BITS], X_LIM);
    assign px_hi = clamp_pix(x_max[CRD_W-1:FRAC_BITS], X_LIM);
    assign py_lo = clamp_pix(y_min[CRD_W-1:FRAC_BITS], Y_LIM);
    assign py_hi = clamp_pix(y_max[CRD_W-1:FRAC_BITS], Y_LIM);

    assign tx_lo = px_lo[TILE_LOG2 +: TX_W];
    assign tx_hi = px_hi[TILE_LOG2 +: TX_W];
    assign ty_lo = py_lo[TILE_LOG2 +: TY_W];
    assign ty_hi = py_hi[TILE_LOG2 +: TY_W];

    // Sample position of the first tile's first pixel center.
    assign org_x = crd_t'({tx_lo, {(TILE_LOG2 + FRAC_BITS){1'b0}}}) | HALF;
    assign org_y = crd_t'({ty_lo, {(TILE_LOG2 + FRAC_BITS){1'b0}}}) | HALF;

    // Signed area term: edge 0 evaluated at vertex 2.
    assign area = (widen(vx[2]) - widen(vx[0])) * (widen(vy[1]) - widen(vy[0]))
                - (widen(vy[2]) - widen(vy[0])) * (widen(vx[1]) - widen(vx[0]));
    assign flip       = (area > 0);
    assign degenerate = (area == 0);

    for (genvar g = 0; g < 3; g++) begin : g_edge
        localparam int NX = (g == 2) ? 0 : g + 1;
        edge_val_t dx, dy, rx, ry, raw_base, raw_sx, raw_sy;

        assign dx = widen(vx[NX]) - widen(vx[g]);
        assign dy = widen(vy[NX]) - widen(vy[g]);
        assign rx = widen(org_x) - widen(vx[g]);
        assign ry = widen(org_y) - widen(vy[g]);

        assign raw_base = rx * dy - ry * dx;
        assign raw_sx   = dy <<< FRAC_BITS;
        assign raw_sy   = -(dx <<< FRAC_BITS);

        assign coef[g].base   = flip ? -raw_base : raw_base;
        assign coef[g].step_x = flip ? -raw_sx   : raw_sx;
        assign coef[g].step_y = flip ? -raw_sy   : raw_sy;
    end

endmodule

// File: rtl/tri_tile_classify.sv
module tri_tile_classify
    import tri_raster_pkg::*;
(
    input  edge_coef_t [2:0]          coef,
    output tile_kind_e                kind,
    output logic [TILE_SAMPLES-1:0]   mask,
    output logic                      emit
);

    localparam edge_val_t LAST = edge_val_t'(TILE_DIM - 1);

    logic [2:0] edge_out;    // whole tile on or outside this edge
    logic [2:0] edge_in;     // whole tile strictly inside this edge
    logic [TILE_SAMPLES-1:0] sample_hit;

    for (genvar g = 0; g < 3; g++) begin : g_corner
        edge_val_t far_x, far_y, near_x, near_y, hi_val, lo_val;

        assign far_x  = coef[g].step_x[EDGE_W-1] ? '0 : LAST * coef[g].step_x;
        assign far_y  = coef[g].step_y[EDGE_W-1] ? '0 : LAST * coef[g].step_y;
        assign near_x = coef[g].step_x[EDGE_W-1] ? LAST * coef[g].step_x : '0;
        assign near_y = coef[g].step_y[EDGE_W-1] ? LAST * coef[g].step_y : '0;

        assign hi_val = coef[g].base + far_x + far_y;
        assign lo_val = coef[g].base + near_x + near_y;

        assign edge_out[g] = !lo_val[EDGE_W-1];
        assign edge_in[g]  = hi_val[EDGE_W-1];
    end

    for (genvar gj = 0; gj < TILE_DIM; gj++) begin : g_row
        for (genvar gi = 0; gi < TILE_DIM; gi++) begin : g_col
            localparam int SI = gj * TILE_DIM + gi;
            logic [2:0] neg;
            for (genvar g = 0; g < 3; g++) begin : g_eval
                edge_val_t v;
                assign v = coef[g].base
                         + edge_val_t'(gi) * coef[g].step_x
                         + edge_val_t'(gj) * coef[g].step_y;
                assign neg[g] = v[EDGE_W-1];
            end
            assign sample_hit[SI] = &neg;
        end
    end

    always_comb begin
        if (|edge_out) begin
            kind = TK_REJECT;
            mask = '0;
        end else if (&edge_in) begin
            kind = TK_FULL;
            mask = '1;
        end else begin
            kind = TK_PARTIAL;
            mask = sample_hit;
        end
    end

    assign emit = (kind != TK_REJECT) && (mask != '0);

endmodule

// File: rtl/tri_tile_walker.sv
module tri_tile_walker
    import tri_raster_pkg::*;
#(
    parameter int TX_W = 4,
    parameter int TY_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_fire,
    input  logic                 setup_degen,
    input  edge_coef_t [2:0]     setup_coef,
    input  logic [TX_W-1:0]      setup_tx_lo,
    input  logic [TX_W-1:0]      setup_tx_hi,
    input  logic [TY_W-1:0]      setup_ty_lo,
    input  logic [TY_W-1:0]      setup_ty_hi,
    input  logic                 tile_emit,
    input  logic                 out_ready,
    output logic                 idle,
    output logic                 out_valid,
    output edge_coef_t [2:0]     tile_coef,
    output logic [TX_W-1:0]      tile_x,
    output logic [TY_W-1:0]      tile_y
);

    walk_state_e state;
    edge_val_t   sx   [3];
    edge_val_t   sy   [3];
    edge_val_t   cur  [3];
    edge_val_t   row  [3];
    logic [TX_W-1:0] tx_lo, tx_hi;
    logic [TY_W-1:0] ty_hi;
    logic advance;

    assign idle      = (state == WS_IDLE);
    assign out_valid = (state == WS_WALK) && tile_emit;
    assign advance   = (state == WS_WALK) && (!tile_emit || out_ready);

    always_comb begin
        for (int e = 0; e < 3; e++) begin
            tile_coef[e].step_x = sx[e];
            tile_coef[e].step_y = sy[e];
            tile_coef[e].base   = cur[e];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WS_IDLE;
            tile_x <= '0;
            tile_y <= '0;
            tx_lo  <= '0;
            tx_hi  <= '0;
            ty_hi  <= '0;
            for (int e = 0; e < 3; e++) begin
                sx[e]  <= '0;
                sy[e]  <= '0;
                cur[e] <= '0;
                row[e] <= '0;
            end
        end else begin
            unique case (state)
                WS_IDLE: begin
                    if (in_fire) state <= WS_LOAD;
                end
                WS_LOAD: begin
                    if (setup_degen) begin
                        state <= WS_IDLE;
                    end else begin
                        state  <= WS_WALK;
                        tile_x <= setup_tx_lo;
                        tile_y <= setup_ty_lo;
                        tx_lo  <= setup_tx_lo;
                        tx_hi  <= setup_tx_hi;
                        ty_hi  <= setup_ty_hi;
                        for (int e = 0; e < 3; e++) begin
                            sx[e]  <= setup_coef[e].step_x;
                            sy[e]  <= setup_coef[e].step_y;
                            cur[e] <= setup_coef[e].base;
                            row[e] <= setup_coef[e].base;
                        end
                    end
                end
                WS_WALK: begin
                    if (advance) begin
                        if (tile_x == tx_hi) begin
                            if (tile_y == ty_hi) begin
                                state <= WS_IDLE;
                            end else begin
                                tile_y <= tile_y + 1'b1;
                                tile_x <= tx_lo;
                                for (int e = 0; e < 3; e++) begin
                                    row[e] <= row[e] + (sy[e] <<< TILE_LOG2);
                                    cur[e] <= row[e] + (sy[e] <<< TILE_LOG2);
                                end
                            end
                        end else begin
                            tile_x <= tile_x + 1'b1;
                            for (int e = 0; e < 3; e++)
                                cur[e] <= cur[e] + (sx[e] <<< TILE_LOG2);
                        end
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tri_coverage_raster.sv
module tri_coverage_raster
    import tri_raster_pkg::*;
#(
    parameter int SCR_W = 64,
    parameter int SCR_H = 64,
    localparam int TX_W = (SCR_W / TILE_DIM > 1) ? $clog2(SCR_W / TILE_DIM) : 1,
    localparam int TY_W = (SCR_H / TILE_DIM > 1) ? $clog2(SCR_H / TILE_DIM) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [CRD_W-1:0]         v0_x,
    input  logic [CRD_W-1:0]         v0_y,
    input  logic [CRD_W-1:0]         v1_x,
    input  logic [CRD_W-1:0]         v1_y,
    input  logic [CRD_W-1:0]         v2_x,
    input  logic [CRD_W-1:0]         v2_y,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [TX_W-1:0]          out_tile_x,
    output logic [TY_W-1:0]          out_tile_y,
    output logic [TILE_SAMPLES-1:0]  out_mask,
    output logic                     out_full
);

    crd_t [2:0] vx_q, vy_q;
    logic in_fire;
    logic idle;

    edge_coef_t [2:0] setup_coef;
    logic setup_degen;
    logic [TX_W-1:0] s_tx_lo, s_tx_hi;
    logic [TY_W-1:0] s_ty_lo, s_ty_hi;

    edge_coef_t [2:0] tile_coef;
    tile_kind_e tile_kind;
    logic tile_emit;

    assign in_ready = idle;
    assign in_fire  = in_valid && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            vx_q <= '0;
            vy_q <= '0;
        end else if (in_fire) begin
            vx_q <= {v2_x, v1_x, v0_x};
            vy_q <= {v2_y, v1_y, v0_y};
        end
    end

    tri_edge_setup #(
        .SCR_W (SCR_W),
        .SCR_H (SCR_H),
        .TX_W  (TX_W),
        .TY_W  (TY_W)
    ) u_setup (
        .vx         (vx_q),
        .vy         (vy_q),
        .coef       (setup_coef),
        .degenerate (setup_degen),
        .tx_lo      (s_tx_lo),
        .tx_hi      (s_tx_hi),
        .ty_lo      (s_ty_lo),
        .ty_hi      (s_ty_hi)
    );

    tri_tile_walker #(
        .TX_W (TX_W),
        .TY_W (TY_W)
    ) u_walk (
        .clk         (clk),
        .rst         (rst),
        .in_fire     (in_fire),
        .setup_degen (setup_degen),
        .setup_coef  (setup_coef),
        .setup_tx_lo (s_tx_lo),
        .setup_tx_hi (s_tx_hi),
        .setup_ty_lo (s_ty_lo),
        .setup_ty_hi (s_ty_hi),
        .tile_emit   (tile_emit),
        .out_ready   (out_ready),
        .idle        (idle),
        .out_valid   (out_valid),
        .tile_coef   (tile_coef),
        .tile_x      (out_tile_x),
        .tile_y      (out_tile_y)
    );

    tri_tile_classify u_class (
        .coef (tile_coef),
        .kind (tile_kind),
        .mask (out_mask),
        .emit (tile_emit)
    );

    assign out_full = (tile_kind == TK_FULL);

endmodule

// File: rtl/tri_coverage_raster_chk.sv
module tri_coverage_raster_chk
    import tri_raster_pkg::*;
#(
    parameter int SCR_W = 64,
    parameter int SCR_H = 64,
    parameter int TX_W  = 4,
    parameter int TY_W  = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [TX_W-1:0]         out_tile_x,
    input logic [TY_W-1:0]         out_tile_y,
    input logic [TILE_SAMPLES-1:0] out_mask,
    input logic                    out_full
);

    logic                 have_last;
    logic [TY_W+TX_W-1:0] last_key;

    always_ff @(posedge clk) begin
        if (rst) begin
            have_last <= 1'b0;
            last_key  <= '0;
        end else if (in_valid && in_ready) begin
            have_last <= 1'b0;
        end else if (out_valid && out_ready) begin
            have_last <= 1'b1;
            last_key  <= {out_tile_y, out_tile_x};
        end
    end

    // R9
    hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_mask) && $stable(out_full)
                                    && $stable(out_tile_x) && $stable(out_tile_y));

    // R10
    busy_out_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R10
    accept_drop_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> !in_ready);

    // R8
    on_screen_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (int'(out_tile_x) < SCR_W / TILE_DIM) && (int'(out_tile_y) < SCR_H / TILE_DIM));

    // R6
    row_major_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && have_last |-> {out_tile_y, out_tile_x} > last_key);

    // R7
    partial_not_full_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_full |-> out_mask != '1);

endmodule

bind tri_coverage_raster tri_coverage_raster_chk #(
    .SCR_W (SCR_W),
    .SCR_H (SCR_H),
    .TX_W  (TX_W),
    .TY_W  (TY_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_tile_x (out_tile_x),
    .out_tile_y (out_tile_y),
    .out_mask   (out_mask),
    .out_full   (out_full)
);

// File: tb/tri_coverage_raster_tb_top.sv
`timescale 1ns/1ps
module tri_coverage_raster_tb_top;
    import tri_raster_pkg::*;

    localparam int SW = 64;
    localparam int SH = 64;
    localparam int NTX = SW / 4;
    localparam int NTY = SH / 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [CRD_W-1:0] v0_x = '0, v0_y = '0, v1_x = '0, v1_y = '0, v2_x = '0, v2_y = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [3:0] out_tile_x, out_tile_y;
    logic [15:0] out_mask;
    logic out_full;

    always #2.5 clk = ~clk;

    tri_coverage_raster #(.SCR_W(SW), .SCR_H(SH)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .v0_x(v0_x), .v0_y(v0_y), .v1_x(v1_x), .v1_y(v1_y), .v2_x(v2_x), .v2_y(v2_y),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_tile_x(out_tile_x), .out_tile_y(out_tile_y),
        .out_mask(out_mask), .out_full(out_full)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int rdy_mode = 0;

    int got_n = 0;
    int got_tx [256];
    int got_ty [256];
    int got_mk [256];
    int got_fl [256];
    int exp_n;
    int exp_tx [256];
    int exp_ty [256];
    int exp_mk [256];

    longint tvx [3];
    longint tvy [3];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int ref_mask(input int tx, input int ty);
        longint area, e, sx, sy, dx, dy;
        int m;
        bit pos, neg;
        m = 0;
        area = (tvx[2] - tvx[0]) * (tvy[1] - tvy[0]) - (tvy[2] - tvy[0]) * (tvx[1] - tvx[0]);
        if (area == 0) return 0;
        for (int j = 0; j < 4; j++) begin
            for (int i = 0; i < 4; i++) begin
                sx = longint'((tx * 4 + i) * 16 + 8);
                sy = longint'((ty * 4 + j) * 16 + 8);
                pos = 1'b1;
                neg = 1'b1;
                for (int k = 0; k < 3; k++) begin
                    dx = tvx[(k + 1) % 3] - tvx[k];
                    dy = tvy[(k + 1) % 3] - tvy[k];
                    e = (sx - tvx[k]) * dy - (sy - tvy[k]) * dx;
                    if (!(e > 0)) pos = 1'b0;
                    if (!(e < 0)) neg = 1'b0;
                end
                if ((area > 0) ? pos : neg) m |= (1 << (j * 4 + i));
            end
        end
        return m;
    endfunction

    // Output monitor: drives out_ready, records transfers, checks stalls.
    initial begin
        bit stall_pend;
        int s_tx, s_ty, s_mk, s_fl;
        stall_pend = 1'b0;
        s_tx = 0; s_ty = 0; s_mk = 0; s_fl = 0;
        forever begin
            @(negedge clk);
            if (stall_pend) begin
                // R9: stalled tile held unchanged
                chk(out_valid && out_tile_x == s_tx && out_tile_y == s_ty
                    && out_mask == s_mk && out_full == s_fl,
                    "R9", "stalled tile changed", {out_valid, out_mask}, {1'b1, s_mk[15:0]});
            end
            out_ready = (rdy_mode == 1) ? 1'b1 : (($urandom % 4) != 0);
            #1;
            stall_pend = out_valid && !out_ready;
            if (stall_pend) begin
                s_tx = out_tile_x; s_ty = out_tile_y; s_mk = out_mask; s_fl = out_full;
            end
            if (out_valid && out_ready && got_n < 256) begin
                got_tx[got_n] = out_tile_x;
                got_ty[got_n] = out_tile_y;
                got_mk[got_n] = out_mask;
                got_fl[got_n] = out_full;
                got_n++;
            end
        end
    end

    task automatic run_tri(input int ax, input int ay, input int bx, input int by,
                           input int cx, input int cy, input string req);
        tvx[0] = ax; tvy[0] = ay; tvx[1] = bx; tvy[1] = by; tvx[2] = cx; tvy[2] = cy;
        exp_n = 0;
        for (int ty = 0; ty < NTY; ty++) begin
            for (int tx = 0; tx < NTX; tx++) begin
                int m;
                m = ref_mask(tx, ty);
                if (m != 0) begin
                    exp_tx[exp_n] = tx; exp_ty[exp_n] = ty; exp_mk[exp_n] = m;
                    exp_n++;
                end
            end
        end
        while (!in_ready) @(negedge clk);
        got_n = 0;
        in_valid = 1'b1;
        v0_x = CRD_W'(ax); v0_y = CRD_W'(ay);
        v1_x = CRD_W'(bx); v1_y = CRD_W'(by);
        v2_x = CRD_W'(cx); v2_y = CRD_W'(cy);
        @(negedge clk);
        in_valid = 1'b0;
        // R10: busy right after acceptance
        chk(in_ready == 1'b0, "R10", "in_ready after accept", in_ready, 0);
        while (!in_ready) @(negedge clk);
        chk(got_n == exp_n, req, "tile count", got_n, exp_n);
        for (int k = 0; k < exp_n && k < got_n; k++) begin
            // R6: row-major position of each emitted tile
            chk(got_tx[k] == exp_tx[k] && got_ty[k] == exp_ty[k], "R6", "tile position",
                got_ty[k] * 256 + got_tx[k], exp_ty[k] * 256 + exp_tx[k]);
            // R5: mask encoding bit j*4+i
            chk(got_mk[k] == exp_mk[k], req, "tile mask", got_mk[k], exp_mk[k]);
            // R7: full flag exactly when all samples covered
            chk(got_fl[k] == (exp_mk[k] == 16'hffff), "R7", "full flag",
                got_fl[k], exp_mk[k] == 16'hffff);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "reset outputs",
            {in_ready, out_valid}, 2'b10);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "after reset",
            {in_ready, out_valid}, 2'b10);

        // R5: ordinary triangle, one winding
        run_tri(2*16, 2*16, 30*16, 5*16, 10*16, 28*16, "R5");
        // R3: same triangle, opposite winding
        run_tri(2*16, 2*16, 10*16, 28*16, 30*16, 5*16, "R3");
        // R2: edges through sample centers, on-edge samples excluded
        run_tri(8, 8, 136, 8, 8, 136, "R2");
        run_tri(8, 8, 8, 136, 136, 8, "R2");
        // R4: zero area
        run_tri(16, 16, 80, 80, 144, 144, "R4");
        run_tri(40, 40, 40, 40, 40, 40, "R4");
        // R8 / R11: vertices beyond the screen, extreme coordinates
        rdy_mode = 1;
        run_tri(0, 0, 4095, 0, 0, 4095, "R8");
        rdy_mode = 0;
        run_tri(4095, 4095, 0, 4095, 4095, 0, "R11");
        run_tri(100*16, 100*16, 120*16, 100*16, 100*16, 120*16, "R8");
        // R6: thin sliver, many rejected tiles
        run_tri(1*16, 3*16, 63*16, 5*16, 2*16, 6*16, "R6");
        begin
            bit in_scr;
            in_scr = 1'b1;
            for (int k = 0; k < got_n; k++)
                if (got_tx[k] >= NTX || got_ty[k] >= NTY) in_scr = 1'b0;
            chk(in_scr, "R8", "tiles on screen", in_scr, 1);
        end
        // Random triangles
        for (int t = 0; t < 40; t++) begin
            int lim;
            lim = (t % 4 == 0) ? 4095 : 72 * 16;
            run_tri($urandom_range(0, lim), $urandom_range(0, lim), $urandom_range(0, lim),
                    $urandom_range(0, lim), $urandom_range(0, lim), $urandom_range(0, lim), "R2");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R10 watchdog: got 0 expected 1 (run did not complete)");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule